// File: doc/BRIEF.md
# State Dwell Lockup Trigger

This block watches the state register of another controller and reports a hang. A hang here means the watched value stays on one programmed code for longer than a programmed number of cycles. A typical case is a cache controller that sits in a fault-wait state and never leaves it. When the run of identical values grows long enough, the block raises a single-cycle trigger pulse and sets a sticky flag. At the same moment it latches the instruction word and program counter present on that cycle, so the cause of the stall can be read out later.

Run detection uses a three-state sequencer (idle, counting, fired) and a run-length counter. A run begins in idle on the first matching cycle, and the counter starts from zero at that point. While counting, the block first compares the counter with the threshold. If the threshold is reached, the block fires whatever the watched value is on that cycle. Otherwise it either extends the run or drops it and returns to idle. The match code and the threshold are copied into shadow registers only while the sequencer is idle. The fired state is terminal until clear or reset. A typical setting is code 0x15 with a threshold of 100.

Top module: `dwell_watch_top`

## Requirements
- R1: During and right after reset, trig_o, triggered_o, cap_insn_o and cap_pc_o are all zero.
- R2: In idle, a cycle where state_i equals match_code_i starts a run with the counter at zero. A non-matching cycle leaves the block idle.
- R3: With threshold L and a run starting on cycle c, L+1 matching cycles c..c+L cause the decision on cycle c+1+L. trig_o and triggered_o are then high on cycle c+2+L.
- R4: While counting, a cycle where state_i differs from the shadowed code, with the threshold not yet reached, returns the block to idle. The next run counts from zero again.
- R5: The threshold test has priority: on the deciding cycle the block fires even if state_i no longer matches.
- R6: trig_o is high for exactly one cycle per firing. triggered_o stays high until clear_i or reset.
- R7: cap_insn_o and cap_pc_o take insn_i and pc_i from the deciding cycle and then hold steady until clear.
- R8: clear_i is synchronous and takes priority over everything else. On the next cycle the block is idle, the counter is zero, and triggered_o, trig_o and both captures are zero.
- R9: The match code and threshold are sampled only while idle. Changes to match_code_i or dwell_limit_i during a run do not alter its outcome or timing.
- R10: A threshold of zero fires on the cycle after the first match: a single matching cycle c gives trig_o on cycle c+2.
- R11: Once fired, the block makes no further transitions and emits no further pulse, whatever state_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear back to idle |
| state_i | input | STATE_W (32) | Watched state value |
| match_code_i | input | STATE_W (32) | Code whose dwell is measured |
| dwell_limit_i | input | CNT_W (16) | Dwell threshold |
| insn_i | input | INSN_W (32) | Instruction word to capture |
| pc_i | input | PC_W (64) | Program counter to capture |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky fired flag |
| cap_insn_o | output | INSN_W (32) | Captured instruction word |
| cap_pc_o | output | PC_W (64) | Captured program counter |

## Verification
Every output is registered. A result that depends on an input applied before edge P therefore shows up on the ports just after P. The bench drives inputs on falling edges and reads outputs on the next falling edge. It expects the outputs one edge after the run is entered plus L+1 edges, which puts the pulse on cycle c+2+L. Clear is seen after one edge, and a capture appears together with its pulse. A behavioural model is updated on each rising edge and compared on every falling edge. Directed checks at the exact due cycle cover the threshold priority, run restart, mid-run reprogramming and the zero-threshold case.

// File: rtl/dwell_pkg.sv
package dwell_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_COUNT = 2'd1,
    SEQ_FIRED = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dwell_cfg_shadow.sv
module dwell_cfg_shadow #(
  parameter int CODE_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  limit_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      limit_q <= '0;
    end else if (load_i) begin
      code_q  <= code_i;
      limit_q <= limit_i;
    end
  end

  assign code_o  = code_q;
  assign limit_o = limit_q;

  // config frozen outside idle
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(code_o) && $stable(limit_o)));
endmodule

// File: rtl/dwell_run_counter.sv
module dwell_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == limit_i);

  assert_run_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_run_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/dwell_seq.sv
module dwell_seq
  import dwell_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       is_match_i,
  input  logic       hit_i,
  output seq_state_e state_o,
  output logic       cfg_load_o,
  output logic       cnt_clr_o,
  output logic       cnt_inc_o,
  output logic       fire_o,
  output logic       trig_o
);
  seq_state_e state_q, state_d;
  logic       trig_q;

  always_comb begin
    state_d = state_q;
    if (clear_i) begin
      state_d = SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE:  if (is_match_i) state_d = SEQ_COUNT;
        SEQ_COUNT: begin
          // threshold test first, watched value ignored once reached
          if (hit_i)            state_d = SEQ_FIRED;
          else if (!is_match_i) state_d = SEQ_IDLE;
        end
        SEQ_FIRED: state_d = SEQ_FIRED;
        default:   state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= fire_o;
    end
  end

  assign state_o    = state_q;
  assign cfg_load_o = (state_q == SEQ_IDLE);
  assign cnt_clr_o  = clear_i || ((state_q == SEQ_IDLE) && is_match_i);
  assign cnt_inc_o  = !clear_i && (state_q == SEQ_COUNT) && !hit_i && is_match_i;
  assign fire_o     = !clear_i && (state_q == SEQ_COUNT) && hit_i;
  assign trig_o     = trig_q;

  assert_fired_terminal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_FIRED && !clear_i) |=> (state_q == SEQ_FIRED));

  assert_run_abandon_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_COUNT && !hit_i && !is_match_i && !clear_i) |=> (state_q == SEQ_IDLE));

  assert_run_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && is_match_i && !clear_i) |=> (state_q == SEQ_COUNT));
endmodule

// File: rtl/dwell_capture.sv
module dwell_capture #(
  parameter int INSN_W = 32,
  parameter int PC_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [INSN_W-1:0] insn_o,
  output logic [PC_W-1:0]   pc_o
);
  logic [INSN_W-1:0] insn_q;
  logic [PC_W-1:0]   pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn_q <= '0;
      pc_q   <= '0;
    end else if (clear_i) begin
      insn_q <= '0;
      pc_q   <= '0;
    end else if (load_i) begin
      insn_q <= insn_i;
      pc_q   <= pc_i;
    end
  end

  assign insn_o = insn_q;
  assign pc_o   = pc_q;

  assert_capture_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (insn_o == $past(insn_i) && pc_o == $past(pc_i)));
endmodule

// File: rtl/dwell_watch_top.sv
module dwell_watch_top
  import dwell_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int CNT_W   = 16,
  parameter int INSN_W  = 32,
  parameter int PC_W    = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] match_code_i,
  input  logic [CNT_W-1:0]   dwell_limit_i,
  input  logic [INSN_W-1:0]  insn_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               trig_o,
  output logic               triggered_o,
  output logic [INSN_W-1:0]  cap_insn_o,
  output logic [PC_W-1:0]    cap_pc_o
);
  seq_state_e         seq_state;
  logic               cfg_load, cnt_clr, cnt_inc, fire, hit, is_match;
  logic [STATE_W-1:0] code_q, code_act;
  logic [CNT_W-1:0]   limit_q, cnt;

  dwell_cfg_shadow #(.CODE_W(STATE_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load),
    .code_i  (match_code_i),
    .limit_i (dwell_limit_i),
    .code_o  (code_q),
    .limit_o (limit_q)
  );

  // idle compares against the live code, a run against its frozen copy
  assign code_act = cfg_load ? match_code_i : code_q;
  assign is_match = (state_i == code_act);

  dwell_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (limit_q),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  dwell_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .is_match_i (is_match),
    .hit_i      (hit),
    .state_o    (seq_state),
    .cfg_load_o (cfg_load),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .fire_o     (fire),
    .trig_o     (trig_o)
  );

  dwell_capture #(.INSN_W(INSN_W), .PC_W(PC_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .load_i  (fire),
    .insn_i  (insn_i),
    .pc_i    (pc_i),
    .insn_o  (cap_insn_o),
    .pc_o    (cap_pc_o)
  );

  assign triggered_o = (seq_state == SEQ_FIRED);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_sticky_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !clear_i) |=> triggered_o);

  assert_pulse_on_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> trig_o);

  assert_capture_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !clear_i) |=> ($stable(cap_insn_o) && $stable(cap_pc_o)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!triggered_o && !trig_o && cap_insn_o == '0 && cap_pc_o == '0 && cnt == '0));

  assert_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == SEQ_COUNT) |-> (cnt <= limit_q));
endmodule

// File: tb/dwell_watch_top_test.sv
module dwell_watch_top_test;
  localparam int MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [31:0] st = '0, code = 32'h15, insn = '0;
  logic [15:0] lim = 16'd100;
  logic [63:0] pc = '0;
  logic        trig, flag;
  logic [31:0] cap_insn;
  logic [63:0] cap_pc;

  int total = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // model state
  int          m_mode = 0, m_run = 0, m_lim = 0;
  logic [31:0] m_code = '0, e_insn = '0;
  logic [63:0] e_pc = '0;
  bit          e_trig = 0, e_flag = 0;

  always #2 clk = ~clk;  // 250 MHz

  dwell_watch_top uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .state_i(st),
    .match_code_i(code), .dwell_limit_i(lim), .insn_i(insn), .pc_i(pc),
    .trig_o(trig), .triggered_o(flag), .cap_insn_o(cap_insn), .cap_pc_o(cap_pc)
  );

  task automatic chk(input string req, input string what, input bit ok,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // behavioural reference: dwell run length against a code latched at run start
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_run = 0; e_trig = 0; e_flag = 0; e_insn = '0; e_pc = '0;
    end else if (clear) begin
      m_mode = 0; m_run = 0; e_trig = 0; e_flag = 0; e_insn = '0; e_pc = '0;
    end else begin
      e_trig = 0;
      if (m_mode == 0) begin
        if (st == code) begin m_mode = 1; m_run = 0; m_code = code; m_lim = int'(lim); end
      end else if (m_mode == 1) begin
        if (m_run == m_lim) begin
          m_mode = 2; e_trig = 1; e_flag = 1; e_insn = insn; e_pc = pc;
        end else if (st == m_code) m_run++;
        else m_mode = 0;
      end
    end
  end

  always @(negedge clk) begin
    chk(cur_req, "model trig", trig == e_trig, 64'(trig), 64'(e_trig));
    chk(cur_req, "model flag", flag == e_flag, 64'(flag), 64'(e_flag));
    chk(cur_req, "model cap_insn", cap_insn == e_insn, 64'(cap_insn), 64'(e_insn));
    chk(cur_req, "model cap_pc", cap_pc == e_pc, cap_pc, e_pc);
  end

  always @(posedge clk) begin
    if (cyc > MAX_CYC) begin
      chk("watchdog", "timeout", 1'b0, 64'(cyc), 64'(MAX_CYC));
      finish_run();
    end
  end

  task automatic do_clear();
    st = '0; clear = 1'b1; step(1); clear = 1'b0;
    chk("R8", "flag after clear", flag == 1'b0, 64'(flag), 0);
    chk("R8", "cap after clear", cap_insn == '0 && cap_pc == '0, cap_pc, 0);
  endtask

  initial begin
    step(3);
    chk("R1", "reset outputs", !trig && !flag && cap_insn == '0 && cap_pc == '0, 64'(flag), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "post reset", !trig && !flag, 64'(flag), 0);

    // R3 / R5 / R7: L=3, value drops on deciding cycle
    cur_req = "R3"; lim = 16'd3; code = 32'h15;
    st = 32'h15; insn = 32'h1111_0000; pc = 64'h0;
    step(4);
    chk("R3", "no fire before L+1", flag == 1'b0, 64'(flag), 0);
    st = 32'h7; insn = 32'hcafe_0013; pc = 64'hffff_ffff_8030_8004;
    step(1);
    chk("R5", "fire with mismatch on deciding cycle", trig == 1'b1, 64'(trig), 1);
    chk("R7", "captured insn", cap_insn == 32'hcafe_0013, 64'(cap_insn), 64'hcafe_0013);
    chk("R7", "captured pc", cap_pc == 64'hffff_ffff_8030_8004, cap_pc, 64'hffff_ffff_8030_8004);
    st = 32'h15; insn = 32'h2; pc = 64'h2;
    step(1);
    chk("R6", "pulse width", trig == 1'b0, 64'(trig), 0);
    chk("R6", "sticky flag", flag == 1'b1, 64'(flag), 1);
    cur_req = "R11";
    step(6);
    chk("R11", "no further pulse", trig == 1'b0 && flag == 1'b1, 64'(trig), 0);
    chk("R7", "capture held", cap_insn == 32'hcafe_0013, 64'(cap_insn), 64'hcafe_0013);
    cur_req = "R8";
    do_clear();

    // R2 / R4: run abandoned and restarted
    cur_req = "R4"; lim = 16'd5;
    st = 32'h15; step(1);
    st = 32'h20; step(1);
    chk("R2", "mismatch in idle stays idle", flag == 1'b0, 64'(flag), 0);
    st = 32'h15; step(3);
    st = 32'h20; step(1);
    st = 32'h15; step(6);
    chk("R4", "restart counts from zero", flag == 1'b0, 64'(flag), 0);
    step(1);
    chk("R4", "fires after full new run", trig == 1'b1, 64'(trig), 1);
    do_clear();

    // R9: reprogramming mid-run
    cur_req = "R9"; lim = 16'd4; code = 32'h15;
    st = 32'h15; step(1);
    code = 32'h99; lim = 16'd1;
    step(4);
    chk("R9", "new limit ignored", flag == 1'b0, 64'(flag), 0);
    step(1);
    chk("R9", "old code and limit kept", trig == 1'b1, 64'(trig), 1);
    code = 32'h15;
    do_clear();

    // R10: zero threshold
    cur_req = "R10"; lim = 16'd0;
    st = 32'h15; step(1);
    st = 32'h0; step(1);
    chk("R10", "zero limit fires next cycle", trig == 1'b1 && flag == 1'b1, 64'(trig), 1);
    do_clear();

    // R3 default setting
    cur_req = "R3"; lim = 16'd100;
    st = 32'h15; step(101);
    chk("R3", "no fire at 101 edges", flag == 1'b0, 64'(flag), 0);
    step(1);
    chk("R3", "fire at L+2", trig == 1'b1, 64'(trig), 1);
    do_clear();
    step(4);
    finish_run();
  end
endmodule